// File: doc/BRIEF.md
# SPI Slave-Select Address Dispatcher

The dispatcher sits on an SPI bus whose master has only one active-low slave-select line. It turns that line into many downstream slave selects. At the start of each access it acts as an SPI slave for one byte and reads that byte as an address. For the rest of the access it pulls the matching downstream select low. The clock and MOSI lines go to every downstream slave unchanged. The MISO line of the chosen slave is routed back to the master.

All three SPI inputs are brought into the system clock domain with two-flop synchronizers. Edges are detected in that domain. The system clock must run at least four times faster than SCLK. When the master raises its select, the access ends and every downstream select is released. An access that stops before a full address byte has arrived selects nothing. So does an address at or above the number of implemented outputs.

Top module: `spi_addr_dispatch`

## Requirements
- R1: While reset is held and directly after it, every bit of `slave_cs_no` is 1 and `miso_o` is 0.
- R2: While the first byte of an access is being shifted in, before its eighth rising SCLK edge, every bit of `slave_cs_no` stays 1.
- R3: The address byte is sampled on rising SCLK edges (mode 0), MSB first. Within 4 system clocks of the eighth rising edge, `slave_cs_no[a]` goes low for address `a` and every other bit stays 1.
- R4: Once an address has been taken, the selection does not change while `cs_ni` stays low, whatever data bytes follow.
- R5: Within 4 system clocks of `cs_ni` going high, every bit of `slave_cs_no` returns to 1.
- R6: An access that ends after fewer than 8 rising edges selects nothing. The next access counts its address bits from zero.
- R7: An address of `NUM_SEL` or more selects nothing, and `miso_o` stays 0 for that access.
- R8: `miso_o` is 0 while no downstream select is low. While `slave_cs_no[a]` is low, `miso_o` equals `slave_miso_i[a]`.
- R9: At most one bit of `slave_cs_no` is low at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock from the master |
| mosi_i | input | 1 | SPI data from the master |
| cs_ni | input | 1 | Master slave select, active low |
| miso_o | output | 1 | SPI data returned to the master |
| slave_cs_no | output | NUM_SEL | Downstream slave selects, active low, bit index = address |
| slave_miso_i | input | NUM_SEL | MISO lines of the downstream slaves |

## Verification
The hardest situations to reach from the ports are an access that is cut off part-way through its address byte, and the access that comes straight after it. The first must leave every select high. The second must count its address bits from zero. The stimulus aborts accesses after 5 and after 7 address bits, then at once runs a full access, and the scoreboard expects exactly one select event for it. Addresses just past the implemented range and the all-ones address are also sent. In between, the downstream MISO pattern is changed during data bytes, which shows that the returned line follows the selected slave.

// File: rtl/spi_disp_pkg.sv
package spi_disp_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned CNT_W  = $clog2(ADDR_W + 1);
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef enum logic {PH_ADDR = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/spi_disp_sync.sv
module spi_disp_sync #(
  parameter int unsigned        WIDTH     = 1,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_disp_addr.sv
module spi_disp_addr
  import spi_disp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sclk_s_i,
  input  logic  mosi_s_i,
  input  logic  cs_ns_i,
  output addr_t addr_o,
  output logic  addr_vld_o
);
  logic   sclk_q;
  logic   sclk_rise;
  cnt_t   cnt_q;
  addr_t  shift_q, addr_q;
  addr_t  shift_nxt;
  phase_e phase_q;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign shift_nxt = {shift_q[ADDR_W-2:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else         sclk_q <= sclk_s_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shift_q <= '0;
      addr_q  <= '0;
      phase_q <= PH_ADDR;
    end else if (cs_ns_i) begin
      // idle or end of access: restart the address count
      cnt_q   <= '0;
      shift_q <= '0;
      addr_q  <= '0;
      phase_q <= PH_ADDR;
    end else if (sclk_rise && phase_q == PH_ADDR) begin
      shift_q <= shift_nxt;
      cnt_q   <= cnt_q + cnt_t'(1);
      if (cnt_q == cnt_t'(ADDR_W - 1)) begin
        addr_q  <= shift_nxt;
        phase_q <= PH_DATA;
      end
    end
  end

  assign addr_o     = addr_q;
  assign addr_vld_o = (phase_q == PH_DATA);

  AST_NO_EARLY_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ns_i && phase_q == PH_ADDR && cnt_q < cnt_t'(ADDR_W - 1)) |=> (phase_q == PH_ADDR)); // R2
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DATA && !cs_ns_i) |=> ($stable(addr_q) && phase_q == PH_DATA)); // R4
  AST_END_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ns_i |=> (phase_q == PH_ADDR && cnt_q == '0)); // R6
endmodule

// File: rtl/spi_disp_decode.sv
module spi_disp_decode
  import spi_disp_pkg::*;
#(
  parameter int unsigned NUM_SEL = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  addr_t              addr_i,
  input  logic               addr_vld_i,
  input  logic [NUM_SEL-1:0] slave_miso_i,
  output logic [NUM_SEL-1:0] slave_cs_no,
  output logic               miso_o
);
  logic [NUM_SEL-1:0] cs_nq;

  for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_nq[i] <= 1'b1;
      else         cs_nq[i] <= !(addr_vld_i && addr_i == addr_t'(i));
    end
  end

  assign slave_cs_no = cs_nq;
  // route back only the line of the slave whose select is low
  assign miso_o      = |(~cs_nq & slave_miso_i);

  AST_ONE_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_nq)); // R9
  AST_OOR_NONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_vld_i && int'(addr_i) >= int'(NUM_SEL)) |=> (&cs_nq)); // R7
  AST_MISO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_nq) |-> !miso_o); // R8
  AST_ADDR_GONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_vld_i |=> (&cs_nq)); // R5
endmodule

// File: rtl/spi_addr_dispatch.sv
module spi_addr_dispatch
  import spi_disp_pkg::*;
#(
  parameter int unsigned NUM_SEL = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               mosi_i,
  input  logic               cs_ni,
  output logic               miso_o,
  output logic [NUM_SEL-1:0] slave_cs_no,
  input  logic [NUM_SEL-1:0] slave_miso_i
);
  logic [2:0] spi_s;
  addr_t      addr;
  logic       addr_vld;

  spi_disp_sync #(
    .WIDTH    (3),
    .RESET_VAL(3'b100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, mosi_i}),
    .q_o   (spi_s)
  );

  spi_disp_addr u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_s_i  (spi_s[1]),
    .mosi_s_i  (spi_s[0]),
    .cs_ns_i   (spi_s[2]),
    .addr_o    (addr),
    .addr_vld_o(addr_vld)
  );

  spi_disp_decode #(
    .NUM_SEL(NUM_SEL)
  ) u_decode (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr),
    .addr_vld_i  (addr_vld),
    .slave_miso_i(slave_miso_i),
    .slave_cs_no (slave_cs_no),
    .miso_o      (miso_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> (&slave_cs_no && !miso_o)); // R1
endmodule

// File: tb/spi_addr_dispatch_tb_top.sv
module spi_addr_dispatch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SEL    = 16;
  localparam int HALF       = 4;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               sclk = 1'b0;
  logic               mosi = 1'b0;
  logic               cs_n = 1'b1;
  logic               miso;
  logic [NUM_SEL-1:0] slave_cs_n;
  logic [NUM_SEL-1:0] slave_miso = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_addr_dispatch #(.NUM_SEL(NUM_SEL)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .sclk_i      (sclk),
    .mosi_i      (mosi),
    .cs_ni       (cs_n),
    .miso_o      (miso),
    .slave_cs_no (slave_cs_n),
    .slave_miso_i(slave_miso)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [NUM_SEL-1:0] sel_mask(input int a);
    sel_mask = ~(NUM_SEL'(1) << a);
  endfunction

  task automatic send_bit(input logic b);
    mosi = b;
    repeat (HALF) @(negedge clk);
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  // abits < 8 aborts during the address byte
  task automatic spi_access(input logic [7:0] addr, input int abits, input int nbytes);
    bit hit;
    hit = (abits >= 8) && (int'(addr) < NUM_SEL);
    if (hit) exp_q.push_back(int'(addr));
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < 8 && k < abits; k++) begin
      chk(&slave_cs_n, "R2 select during address", 32'(slave_cs_n), 32'(sel_mask(-1) | '1));
      chk(miso == 1'b0, "R8 miso during address", 32'(miso), 0);
      send_bit(addr[7-k]);
    end
    repeat (HALF) @(negedge clk);
    if (abits < 8) begin
      chk(&slave_cs_n, "R6 short access selects", 32'(slave_cs_n), 32'({NUM_SEL{1'b1}}));
    end else if (hit) begin
      chk(slave_cs_n == sel_mask(int'(addr)), "R3 addressed select", 32'(slave_cs_n), 32'(sel_mask(int'(addr))));
      chk(miso == slave_miso[addr[3:0]], "R8 miso routed", 32'(miso), 32'(slave_miso[addr[3:0]]));
    end else begin
      chk(&slave_cs_n, "R7 out of range selects", 32'(slave_cs_n), 32'({NUM_SEL{1'b1}}));
      chk(miso == 1'b0, "R7 out of range miso", 32'(miso), 0);
    end
    for (int n = 0; n < nbytes && abits >= 8; n++) begin
      for (int k = 7; k >= 0; k--) send_bit(addr[k] ^ logic'(n[0]) ^ logic'(k[0]));
      slave_miso = ~slave_miso;
      repeat (2) @(negedge clk);
      if (hit) begin
        chk(slave_cs_n == sel_mask(int'(addr)), "R4 select held over data", 32'(slave_cs_n), 32'(sel_mask(int'(addr))));
        chk(miso == slave_miso[addr[3:0]], "R8 miso follows slave", 32'(miso), 32'(slave_miso[addr[3:0]]));
      end else begin
        chk(&slave_cs_n && !miso, "R7 nothing during data", 32'(slave_cs_n), 32'({NUM_SEL{1'b1}}));
      end
    end
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(&slave_cs_n, "R5 release after access", 32'(slave_cs_n), 32'({NUM_SEL{1'b1}}));
    chk(miso == 1'b0, "R8 miso idle", 32'(miso), 0);
    repeat (HALF) @(negedge clk);
  endtask

  // scoreboard monitor: every new select event must match the next expected address
  initial begin
    logic [NUM_SEL-1:0] prev;
    prev = '1;
    forever begin
      @(negedge clk);
      if (rst_ni && slave_cs_n != prev && slave_cs_n != '1) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected select", 32'(slave_cs_n), 32'({NUM_SEL{1'b1}}));
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(slave_cs_n == sel_mask(e), "R3 scoreboard select", 32'(slave_cs_n), 32'(sel_mask(e)));
        end
      end
      prev = slave_cs_n;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    slave_miso = 16'hA5C3;
    repeat (3) @(negedge clk);
    chk(&slave_cs_n && !miso, "R1 selects in reset", 32'(slave_cs_n), 32'({NUM_SEL{1'b1}}));
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    chk(&slave_cs_n && !miso, "R1 selects after reset", 32'(slave_cs_n), 32'({NUM_SEL{1'b1}}));

    spi_access(8'd5, 8, 2);
    spi_access(8'd0, 8, 1);
    slave_miso = 16'h3C96;
    spi_access(8'd15, 8, 3);
    spi_access(8'd16, 8, 1);
    spi_access(8'hFF, 8, 1);
    spi_access(8'h03, 5, 0);
    spi_access(8'd9, 8, 1);
    spi_access(8'h01, 7, 0);
    spi_access(8'd10, 8, 2);
    spi_access(8'd6, 8, 0);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected selects seen", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule